// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter

This block is the front end of a DMA controller. Four peripherals raise request lines that are not tied to the block clock. Each line passes through a synchroniser. It is then gated by an enable bit for its channel. While at least one enabled request is pending, the arbiter raises a bus hold request toward the host and waits for the host's hold acknowledge. Once the acknowledge arrives, the arbiter picks one channel and drives that channel's active-low acknowledge line. The downstream cycle engine learns of the choice through a one-cycle start pulse and a channel index.

The pick follows one of two policies, chosen by a bit in a small mode register. In fixed order, channel 0 always wins. In rotating order, the channel served last drops to the bottom. The mode register also holds the four channel enables. It is written and read back over a plain register port. Reset clears it, so every channel starts disabled.

The decision is held until the cycle engine reports completion. After completion, the arbiter either arbitrates again while keeping the bus, or releases hold and the acknowledge together when nothing enabled is left.

Top module: `dma_req_arbiter`

## Requirements
- R1: While reset is high and after it falls, `cfg_rdata` reads 0, `hold_req` is low, all `ack_n` bits are high and `svc_start` is low.
- R2: A cycle with `cfg_we` high loads `cfg_wdata` into the mode register. Bits [3:0] enable channels 0..3 and bit 4 selects rotating order (1) over fixed order (0). `cfg_rdata` returns the stored value on the next cycle.
- R3: A request on a channel whose enable bit is 0 never raises `hold_req` and never receives an acknowledge.
- R4: From idle, an enabled request driven before clock edge k raises `hold_req` after edge k+2 (two synchroniser stages plus the request register), and not earlier.
- R5: No `ack_n` bit goes low and `svc_start` stays low while `hold_ack` is low.
- R6: In fixed order, the lowest-numbered pending enabled channel wins.
- R7: In rotating order, the search starts at the channel after the one served last, modulo 4. Before any service it starts at channel 0.
- R8: At most one `ack_n` bit is low, and it is bit `svc_chan`. `svc_start` is high for exactly the first cycle of each service.
- R9: Once granted, `svc_chan` and `ack_n` do not change until `svc_done` is seen, even when higher-priority requests arrive.
- R10: The edge that samples `svc_done` deasserts `ack_n`. If no enabled request is pending, the same edge drops `hold_req`. Otherwise `hold_req` stays high and a new arbitration follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Active-high synchronous reset |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | 5 | Mode value: [3:0] enables, [4] rotating order |
| cfg_rdata | output | 5 | Mode register readback |
| req_async | input | 4 | Asynchronous channel request lines |
| hold_ack | input | 1 | Host grants the bus |
| hold_req | output | 1 | Bus hold request to host |
| ack_n | output | 4 | Active-low per-channel acknowledge |
| svc_start | output | 1 | One-cycle pulse when a service begins |
| svc_chan | output | 2 | Index of the channel being served |
| svc_done | input | 1 | Cycle engine reports service complete |

## Verification
The bench builds the block with its defaults: four channels and two synchroniser stages. With four channels, the random mix of enable masks, request patterns and order modes reaches every rotation start point and every masked-out combination within a few dozen trials. With two stages, the hold-request latency is a fixed three cycles, so the bench can check it exactly. Directed cases cover reset, disabled requests, waiting without a bus grant, and a higher-priority request arriving mid-service.

// File: rtl/dma_arb_pkg.sv
`timescale 1ns/1ps
package dma_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_SERVE = 2'd2
  } arb_state_t;
endpackage

// File: rtl/dma_req_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser for a vector of independent request lines.
module dma_req_sync #(
  parameter int NCH    = 4,
  parameter int STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] d_async,
  output logic [NCH-1:0] q_sync
);
  logic [NCH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/dma_mode_reg.sv
`timescale 1ns/1ps
// Mode register: channel enables plus order-select bit.
module dma_mode_reg #(
  parameter int NCH = 4,
  localparam int CFGW = NCH + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [CFGW-1:0] wdata,
  output logic [CFGW-1:0] rdata,
  output logic [NCH-1:0]  chan_en,
  output logic            rotate
);
  logic [CFGW-1:0] mode_q;

  always_ff @(posedge clk) begin
    if (rst)     mode_q <= '0;
    else if (we) mode_q <= wdata;
  end

  assign rdata   = mode_q;
  assign chan_en = mode_q[NCH-1:0];
  assign rotate  = mode_q[NCH];
endmodule

// File: rtl/dma_prio_pick.sv
`timescale 1ns/1ps
// Combinational winner selection, fixed or rotating order.
module dma_prio_pick #(
  parameter int NCH = 4,
  localparam int CW = $clog2(NCH)
) (
  input  logic [NCH-1:0] pend,
  input  logic           rotate,
  input  logic [CW-1:0]  last,
  output logic           any,
  output logic [CW-1:0]  win
);
  int base;
  int idx;

  always_comb begin
    any  = 1'b0;
    win  = '0;
    base = rotate ? (int'(last) + 1) : 0;
    idx  = 0;
    // Walk from lowest priority to highest so the highest-ranked hit is kept.
    for (int k = NCH - 1; k >= 0; k--) begin
      idx = (base + k) % NCH;
      if (pend[idx]) begin
        any = 1'b1;
        win = CW'(idx);
      end
    end
  end
endmodule

// File: rtl/dma_req_arbiter.sv
`timescale 1ns/1ps
module dma_req_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CW   = $clog2(NCH),
  localparam int CFGW = NCH + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [CFGW-1:0] cfg_wdata,
  output logic [CFGW-1:0] cfg_rdata,
  input  logic [NCH-1:0]  req_async,
  input  logic            hold_ack,
  output logic            hold_req,
  output logic [NCH-1:0]  ack_n,
  output logic            svc_start,
  output logic [CW-1:0]   svc_chan,
  input  logic            svc_done
);
  localparam logic [NCH-1:0] ONE = NCH'(1);

  logic [NCH-1:0] req_s;
  logic [NCH-1:0] chan_en;
  logic           rotate;
  logic [NCH-1:0] pend;
  logic           any;
  logic [CW-1:0]  win;
  logic [CW-1:0]  last_q;
  arb_state_t     st_q;

  dma_req_sync #(.NCH(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(req_async), .q_sync(req_s)
  );

  dma_mode_reg #(.NCH(NCH)) u_mode (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .chan_en(chan_en), .rotate(rotate)
  );

  assign pend = req_s & chan_en;

  dma_prio_pick #(.NCH(NCH)) u_pick (
    .pend(pend), .rotate(rotate), .last(last_q), .any(any), .win(win)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      hold_req  <= 1'b0;
      ack_n     <= '1;
      svc_start <= 1'b0;
      svc_chan  <= '0;
      last_q    <= CW'(NCH - 1);
    end else begin
      svc_start <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (any) begin
            hold_req <= 1'b1;
            st_q     <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (!any) begin
            hold_req <= 1'b0;
            st_q     <= ST_IDLE;
          end else if (hold_ack) begin
            svc_chan  <= win;
            ack_n     <= ~(ONE << win);
            svc_start <= 1'b1;
            st_q      <= ST_SERVE;
          end
        end
        ST_SERVE: begin
          if (svc_done) begin
            ack_n  <= '1;
            last_q <= svc_chan;
            if (any) begin
              st_q <= ST_WAIT;
            end else begin
              hold_req <= 1'b0;
              st_q     <= ST_IDLE;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_arb_chk.sv
`timescale 1ns/1ps
module dma_arb_chk #(
  parameter int NCH = 4,
  parameter int CW  = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           hold_ack,
  input logic           hold_req,
  input logic [NCH-1:0] ack_n,
  input logic           svc_start,
  input logic [CW-1:0]  svc_chan,
  input logic           svc_done
);
  AST_ONE_ACK: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~ack_n)); // R8
  AST_START_MATCHES_ACK: assert property (@(posedge clk) disable iff (rst)
    svc_start |-> (ack_n[svc_chan] == 1'b0)); // R8
  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    svc_start |=> !svc_start); // R8
  AST_ACK_NEEDS_GRANT: assert property (@(posedge clk) disable iff (rst)
    ((ack_n != '1) && ($past(ack_n) == '1)) |-> $past(hold_ack)); // R5
  AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
    ((ack_n != '1) && !svc_done) |=> ($stable(svc_chan) && $stable(ack_n))); // R9
  AST_ACK_UNDER_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ack_n != '1) |-> hold_req); // R10
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (rst)
    ((ack_n != '1) && svc_done) |=> (ack_n == '1)); // R10
endmodule

bind dma_req_arbiter dma_arb_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .hold_ack(hold_ack), .hold_req(hold_req),
  .ack_n(ack_n), .svc_start(svc_start), .svc_chan(svc_chan), .svc_done(svc_done)
);

// File: tb/sim_dma_req_arbiter.sv
`timescale 1ns/1ps
module sim_dma_req_arbiter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [4:0] cfg_wdata = '0;
  logic [4:0] cfg_rdata;
  logic [3:0] req_async = '0;
  logic       hold_ack = 1'b0;
  logic       hold_req;
  logic [3:0] ack_n;
  logic       svc_start;
  logic [1:0] svc_chan;
  logic       svc_done = 1'b0;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 1'b0;
  int last_m = 3;

  always #2.5 clk = ~clk;

  dma_req_arbiter u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .req_async(req_async), .hold_ack(hold_ack),
    .hold_req(hold_req), .ack_n(ack_n), .svc_start(svc_start),
    .svc_chan(svc_chan), .svc_done(svc_done)
  );

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_pick(int rem, int rot, int last);
    for (int k = 0; k < 4; k++) begin
      int idx = rot ? (last + 1 + k) % 4 : k;
      if (rem[idx]) return idx;
    end
    return -1;
  endfunction

  task automatic write_cfg(logic [4:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    tick();
    cfg_we = 1'b0;
    chk(cfg_rdata == v, "R2 readback", cfg_rdata, v);
  endtask

  task automatic wait_hold();
    for (int i = 0; i < 20 && !hold_req; i++) tick();
    chk(hold_req == 1'b1, "R4 hold request", hold_req, 1);
  endtask

  task automatic wait_start();
    for (int i = 0; i < 20 && !svc_start; i++) tick();
    chk(svc_start == 1'b1, "R8 start pulse", svc_start, 1);
  endtask

  task automatic finish_svc(int chan, int more);
    svc_done = 1'b1;
    tick();
    svc_done = 1'b0;
    last_m = chan;
    chk(ack_n == 4'hF, "R10 ack released", ack_n, 4'hF);
    chk(hold_req == (more != 0), "R10 hold after done", hold_req, more != 0);
  endtask

  // Serves every enabled request in pat, checking order against the model.
  task automatic serve_all(int pat, int en, int rot);
    int rem = pat & en;
    wait_hold();
    hold_ack = 1'b1;
    while (rem != 0) begin
      int e = exp_pick(rem, rot, last_m);
      wait_start();
      chk(svc_chan == e[1:0], rot ? "R7 rotating winner" : "R6 fixed winner", svc_chan, e);
      chk(ack_n == ~(4'b1 << e), "R8 ack line", ack_n, ~(4'b1 << e));
      req_async[e] = 1'b0;
      rem[e] = 1'b0;
      tick();
      chk(svc_start == 1'b0, "R8 start one cycle", svc_start, 0);
      tick(3);
      chk(svc_chan == e[1:0], "R9 frozen channel", svc_chan, e);
      finish_svc(e, rem);
    end
    hold_ack = 1'b0;
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected<%0d", cycles, 100000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    tick(3);
    chk(cfg_rdata == 0, "R1 mode in reset", cfg_rdata, 0);
    rst = 1'b0;
    tick();
    chk(cfg_rdata == 0, "R1 mode cleared", cfg_rdata, 0);
    chk(hold_req == 0, "R1 hold idle", hold_req, 0);
    chk(ack_n == 4'hF, "R1 acks idle", ack_n, 4'hF);
    chk(svc_start == 0, "R1 no start", svc_start, 0);

    // R3: all channels disabled after reset
    req_async = 4'hF;
    tick(8);
    chk(hold_req == 0, "R3 disabled ignored", hold_req, 0);
    chk(ack_n == 4'hF, "R3 no ack", ack_n, 4'hF);
    req_async = 4'h0;
    tick(4);

    // R2/R4: enable ch1 only, measure latency
    write_cfg(5'b0_0010);
    req_async = 4'b0010;
    tick(2);
    chk(hold_req == 0, "R4 not early", hold_req, 0);
    tick();
    chk(hold_req == 1, "R4 latency", hold_req, 1);
    // R5: no grant, no service
    tick(10);
    chk(ack_n == 4'hF, "R5 wait for grant", ack_n, 4'hF);
    chk(svc_start == 0, "R5 no start", svc_start, 0);
    serve_all(4'b0010, 4'b0010, 0);

    // R9: higher-priority arrival during service
    write_cfg(5'b0_1111);
    req_async = 4'b0100;
    wait_hold();
    hold_ack = 1'b1;
    wait_start();
    chk(svc_chan == 2, "R9 first pick", svc_chan, 2);
    req_async = 4'b0101;
    tick(5);
    chk(svc_chan == 2, "R9 no preempt", svc_chan, 2);
    chk(ack_n == 4'b1011, "R9 ack held", ack_n, 4'b1011);
    req_async[2] = 1'b0;
    tick(4);
    finish_svc(2, 1);
    wait_start();
    chk(svc_chan == 0, "R6 next fixed", svc_chan, 0);
    req_async = 4'h0;
    tick(4);
    finish_svc(0, 0);
    hold_ack = 1'b0;
    tick(2);

    // random trials
    void'($urandom(32'd1234));
    for (int t = 0; t < 60; t++) begin
      int en  = $urandom % 16;
      int rot = $urandom % 2;
      int pat = $urandom % 16;
      if (en == 0) en = 1;
      if ((pat & en) == 0) pat = pat | (en & -en);
      write_cfg(5'(en | (rot << 4)));
      req_async = 4'(pat);
      serve_all(pat, en, rot);
      tick(5);
      chk(hold_req == 0, "R3 masked leftovers", hold_req, 0);
      chk(ack_n == 4'hF, "R3 masked no ack", ack_n, 4'hF);
      req_async = 4'h0;
      tick(4);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule